// File: doc/BRIEF.md
# One-shot countdown event timer

This block is a single-channel event timer intended to stay powered while the rest of the system sleeps, so that it can deliver the next wake-up or scheduling event. It runs directly from the system clock with no prescaler. Software programs a tick count, and the block counts down from it once per clock. When the count runs out, the block latches a pending event. The interrupt line reflects that event only while interrupts are enabled.

Access is through a small register bus made of a write strobe, a read strobe, a byte address and a 32-bit data word. There are two registers, one for control and one for the timeout count. The control enable bit gates everything else. It must be set for a count to be accepted, and it must be written as 1 in the same write for the interrupt-enable and clear bits to take effect. A usual arming sequence writes enable alone, then the tick count, then enable together with interrupt enable. A usual acknowledge is one write of clear plus enable.

Top module: `oneshot_timer`

## Requirements
- R1: After reset, the control register reads 0, the count register reads 0 and `irq` is low.
- R2: The control register is at address 0x40. It has enable in bit 0, interrupt enable in bit 1, read-only pending status in bit 2, and write-only clear in bit 4. Bit 4 and all unused bits read 0. A read of any address other than 0x40 or 0x44 returns 0.
- R3: A write to address 0x44 while enable is 1 loads the count and starts the countdown. A read of 0x44 taken k cycles after the load edge returns N-k while that is positive.
- R4: The countdown is one-shot. The pending bit sets exactly max(N,1) cycles after the load edge, and the count then holds at 0.
- R5: `irq` is high exactly when pending, interrupt enable and enable are all 1.
- R6: A write to 0x44 while enable is 0 is ignored. The count does not change and no countdown starts.
- R7: A control write with bit 0 = 0 clears enable and stops the countdown, freezing the count. It leaves interrupt enable and pending as they were, and ignores bit 4. Setting enable again later does not resume the frozen countdown.
- R8: A control write with bit 0 = 1 takes interrupt enable from bit 1 and, when bit 4 is 1, clears pending. The acknowledge write 0x11 therefore leaves interrupt enable at 0 and `irq` low.
- R9: When the countdown expires in the same cycle as a clear write, pending ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the countdown advances once per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| rd_en | input | 1 | Read strobe; `rdata` is valid in the same cycle |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data; 0 when `rd_en` is low |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to produce from the ports is an expiry that falls on the same edge as a clear write. The bench reaches it by counting its own write strobes. It loads a count of 3, lets two edges pass, and issues the clear write so that its edge lands on the final decrement. The second hard case is the enable-gated behaviour. A frozen count and a retained interrupt-enable bit are only visible through readback. So the bench disables the timer mid-count, attempts a load while disabled, and then re-enables without a load, reading both registers after each step.

// File: rtl/timer_pkg.sv
package timer_pkg;
    // Control bit positions; software depends on these.
    localparam int EN_POS   = 0;
    localparam int IE_POS   = 1;
    localparam int PEND_POS = 2;
    localparam int CLR_POS  = 4;

    typedef struct packed {
        logic en;
        logic ie;
        logic pend;
    } ctrl_t;
endpackage

// File: rtl/timer_ctrl_reg.sv
module timer_ctrl_reg
    import timer_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ctrl_we,
    input  logic  w_en,
    input  logic  w_ie,
    input  logic  w_clr,
    input  logic  expire,
    output ctrl_t ctrl_q
);
    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_we) begin
            ctrl_d.en = w_en;
            // Interrupt controls only change when the same write keeps enable on.
            if (w_en) begin
                ctrl_d.ie = w_ie;
                if (w_clr) begin
                    ctrl_d.pend = 1'b0;
                end
            end
        end
        // A new event outranks a simultaneous clear.
        if (expire) begin
            ctrl_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end
endmodule

// File: rtl/timer_countdown.sv
module timer_countdown #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             stop,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
    } cd_t;

    cd_t cd_d, cd_q;

    always_comb begin
        cd_d   = cd_q;
        expire = 1'b0;
        if (cd_q.run && en) begin
            if (cd_q.cnt <= ONE) begin
                cd_d.cnt = '0;
                cd_d.run = 1'b0;
                expire   = 1'b1;
            end else begin
                cd_d.cnt = cd_q.cnt - ONE;
            end
        end
        if (stop) begin
            cd_d.run = 1'b0;
        end
        if (load) begin
            cd_d.cnt = load_val;
            cd_d.run = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cd_q <= '0;
        end else begin
            cd_q <= cd_d;
        end
    end

    assign count   = cd_q.cnt;
    assign running = cd_q.run;
endmodule

// File: rtl/timer_read_mux.sv
module timer_read_mux
    import timer_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter int                CNT_W    = 32,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h40,
    parameter logic [ADDR_W-1:0] VAL_OFS  = 8'h44
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  ctrl_t             ctrl,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == CTRL_OFS) begin
                rdata[EN_POS]   = ctrl.en;
                rdata[IE_POS]   = ctrl.ie;
                rdata[PEND_POS] = ctrl.pend;
            end else if (addr == VAL_OFS) begin
                rdata = DATA_W'(count);
            end
        end
    end
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
    import timer_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter int                CNT_W    = 32,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h40,
    parameter logic [ADDR_W-1:0] VAL_OFS  = 8'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] count;
    logic             running;
    logic             expire;
    logic             ctrl_we;
    logic             load;
    logic             stop;

    assign ctrl_we = wr_en && (addr == CTRL_OFS);
    assign load    = wr_en && (addr == VAL_OFS) && ctrl_q.en;
    assign stop    = ctrl_we && !wdata[EN_POS];

    timer_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_we (ctrl_we),
        .w_en    (wdata[EN_POS]),
        .w_ie    (wdata[IE_POS]),
        .w_clr   (wdata[CLR_POS]),
        .expire  (expire),
        .ctrl_q  (ctrl_q)
    );

    timer_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctrl_q.en),
        .stop     (stop),
        .load     (load),
        .load_val (wdata[CNT_W-1:0]),
        .count    (count),
        .running  (running),
        .expire   (expire)
    );

    timer_read_mux #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CNT_W    (CNT_W),
        .CTRL_OFS (CTRL_OFS),
        .VAL_OFS  (VAL_OFS)
    ) u_rd (
        .rd_en (rd_en),
        .addr  (addr),
        .ctrl  (ctrl_q),
        .count (count),
        .rdata (rdata)
    );

    assign irq = ctrl_q.pend && ctrl_q.ie && ctrl_q.en;
endmodule

// File: rtl/oneshot_timer_checker.sv
module oneshot_timer_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             en,
    input logic             ie,
    input logic             pend,
    input logic             running,
    input logic             expire,
    input logic             load,
    input logic             val_wr,
    input logic [CNT_W-1:0] count
);
    // R5: interrupt only with both enables set
    p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en && ie && pend));

    // R3: a running counter above one steps down by exactly one
    p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && en && !load && count > CNT_W'(1)) |=> (count == $past(count) - CNT_W'(1)));

    // R6: a value write while disabled leaves the count alone
    p_ignore_val_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (val_wr && !en) |=> $stable(count));

    // R7: a disabled timer never has a countdown in progress
    p_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !running);

    // R9: an expiry always leaves pending set, even against a clear
    p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pend);

    // R4: once finished and not reloaded, the count holds
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !load) |=> $stable(count));
endmodule

bind oneshot_timer oneshot_timer_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq),
    .en      (ctrl_q.en),
    .ie      (ctrl_q.ie),
    .pend    (ctrl_q.pend),
    .running (running),
    .expire  (expire),
    .load    (load),
    .val_wr  (wr_en && (addr == VAL_OFS)),
    .count   (count)
);

// File: tb/oneshot_timer_test.sv
`timescale 1ns/10ps
module oneshot_timer_test;
    localparam logic [7:0] A_CTRL = 8'h40;
    localparam logic [7:0] A_VAL  = 8'h44;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    oneshot_timer uut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr  = a;
        rd_en = 1'b1;
        #0.2;
        d = rdata;
        rd_en = 1'b0;
        #0.1;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] frozen;
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, v); check("R1 ctrl", v, 32'h0);
        rd(A_VAL, v);  check("R1 count", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2 field layout and unmapped address
        wr(A_CTRL, 32'h13);
        rd(A_CTRL, v); check("R2 readback bit4 reads 0", v, 32'h3);
        rd(8'h48, v);  check("R2 unmapped", v, 32'h0);
        rd(8'h00, v);  check("R2 unmapped low", v, 32'h0);

        // R3 R4 R5: sweep of small counts, every cycle
        for (int n = 0; n <= 12; n++) begin
            wr(A_CTRL, 32'h13);
            wr(A_VAL, n);
            for (int k = 0; k <= n + 2; k++) begin
                logic [31:0] exp_cnt;
                logic        exp_p;
                exp_cnt = (k >= n) ? 32'd0 : 32'(n - k);
                exp_p   = (k >= ((n > 1) ? n : 1));
                rd(A_VAL, v);  check("R3 R4 remaining count", v, exp_cnt);
                rd(A_CTRL, v); check("R4 pending timing", v, {29'b0, exp_p, 2'b11});
                check("R5 irq follows pending", {31'b0, irq}, {31'b0, exp_p});
                @(negedge clk);
            end
        end

        // R3 full-width count
        wr(A_CTRL, 32'h13);
        wr(A_VAL, 32'hFFFF_FFFF);
        wait_cyc(2);
        rd(A_VAL, v); check("R3 wide count", v, 32'hFFFF_FFFD);

        // R7 disable freezes the count and keeps ie
        wr(A_CTRL, 32'h13);
        wr(A_VAL, 100);
        wait_cyc(5);
        wr(A_CTRL, 32'h0);
        rd(A_VAL, frozen); check("R7 frozen value", frozen, 32'd94);
        rd(A_CTRL, v);     check("R7 ie kept", v, 32'h2);
        check("R7 irq low", {31'b0, irq}, 32'h0);
        // R6 load ignored while disabled
        wr(A_VAL, 7);
        rd(A_VAL, v); check("R6 load ignored", v, frozen);
        wait_cyc(3);
        rd(A_VAL, v); check("R6 no countdown", v, frozen);
        rd(A_CTRL, v); check("R6 no pending", v, 32'h2);
        // R7 re-enable does not resume
        wr(A_CTRL, 32'h1);
        wait_cyc(3);
        rd(A_VAL, v);  check("R7 no resume", v, frozen);
        rd(A_CTRL, v); check("R7 ctrl after re-enable", v, 32'h1);

        // R7 pending kept through disable, clear ignored while disabled
        wr(A_CTRL, 32'h3);
        wr(A_VAL, 2);
        wait_cyc(3);
        check("R5 irq on expiry", {31'b0, irq}, 32'h1);
        wr(A_CTRL, 32'h0);
        check("R7 irq masked", {31'b0, irq}, 32'h0);
        rd(A_CTRL, v); check("R7 pending kept", v, 32'h6);
        wr(A_CTRL, 32'h10);
        rd(A_CTRL, v); check("R7 clear ignored", v, 32'h6);
        check("R7 irq still low", {31'b0, irq}, 32'h0);
        wr(A_CTRL, 32'h3);
        check("R5 irq back", {31'b0, irq}, 32'h1);
        rd(A_CTRL, v); check("R5 ctrl", v, 32'h7);
        // R8 acknowledge
        wr(A_CTRL, 32'h11);
        check("R8 irq after ack", {31'b0, irq}, 32'h0);
        rd(A_CTRL, v); check("R8 ctrl after ack", v, 32'h1);

        // R5 pending without ie
        wr(A_VAL, 1);
        @(negedge clk);
        check("R5 no irq without ie", {31'b0, irq}, 32'h0);
        rd(A_CTRL, v); check("R5 pending without ie", v, 32'h5);
        wr(A_CTRL, 32'h3);
        check("R8 ie set raises irq", {31'b0, irq}, 32'h1);
        wr(A_CTRL, 32'h11);

        // R9 expiry on the same edge as a clear
        wr(A_CTRL, 32'h3);
        wr(A_VAL, 3);
        wait_cyc(2);
        wr(A_CTRL, 32'h13);
        rd(A_CTRL, v); check("R9 pending survives clear", v, 32'h7);
        check("R9 irq", {31'b0, irq}, 32'h1);
        rd(A_VAL, v);  check("R9 count at zero", v, 32'h0);
        wr(A_CTRL, 32'h13);
        rd(A_CTRL, v); check("R8 later clear works", v, 32'h3);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule